// File: doc/BRIEF.md
# Debug password guard

This block decides whether debug access is allowed. It does so with a 128-bit password kept for each of two security domains, one secure and one non-secure. Each domain has a control register, a status register and four write-only words that stage a candidate password. Software or a debugger stages a candidate and then starts a compare. A match opens debug for that domain until the next cold reset. The same staging words also feed a password update. Compares and updates are multi-cycle operations, and the domain shows itself as busy while one runs.

Access is through a simple synchronous bus with registered read data. A control write takes effect only when its top byte carries a write key. Failed compares are counted, and once they reach a limit the domain refuses any further compare. Updates are counted and stop after seven. The debug-disable and lock bits can only be set. A shared interrupt reports compare errors from either domain. A warm reset clears the working state but keeps the stored password, the counters and the sticky bits. Only a cold reset clears those.

Address map, byte offsets within a domain: control at 0x00, status at 0x04, password words at 0x10, 0x14, 0x18 and 0x1C. Address bit 6 selects the domain: 0 is secure, 1 is non-secure. Unmapped addresses read 0.

Top module: `dbg_pwd_guard`

## Requirements
- R1: After cold reset, both status registers read 0x00000000, both control registers read 0xA5000000, irq_o is 0 and dbg_open_o is 2'b11.
- R2: A control write takes effect only if bits [31:24] of the written value are 0x5A. A write with any other key changes nothing. Control reads always return 0xA5 in bits [31:24].
- R3: Control bit 0 sets the domain's debug-disable bit and control bit 1 sets its lock bit. Software cannot clear either one. A warm reset keeps both, and a cold reset clears both. Status bit 16 reports debug-disable, status bit 17 reports lock, and control bits 0 and 1 read back the same two values.
- R4: Control bit 2 starts a compare of the staged words against the stored password. The domain is busy for OP_CYC cycles. On a match, status bit 18 (password OK) is set and stays set until cold reset. On a mismatch, status bit 4 (compare error) is set. Control bits 2 and 3 read 1 while a compare or an update, respectively, is running.
- R5: While a domain is busy, its status register reads exactly 0x00000001, and every write to that domain is ignored.
- R6: Writing 1 to status bit 4 or bit 5 clears that flag. Writing 0 leaves it unchanged.
- R7: Each mismatch adds one to a failure count. When the count reaches MAX_FAIL (default 3), status bit 6 is set. After that, a compare request does not start, and the domain does not go busy.
- R8: Control bit 3, written with bit 2 equal to 0, copies the staged words into the stored password. It also adds one to status bits [10:8] and sets status bit 5. Once the count is 7, further update requests are refused. A write with both bits 2 and 3 set runs only the compare.
- R9: The password words read 0xFFFFFFFF. Word i stages password bits [32i+31:32i], and all four words take part in a compare.
- R10: Secure control bit 8 enables the interrupt. Secure status bit 1 is 1 while the interrupt is enabled and either domain's compare error is set. irq_o shows the same condition one cycle later.
- R11: When bus_dbg is 1, a domain whose control bit 12 is set ignores the write. When secure control bit 13 is set, every access with bus_dbg=1 is blocked: writes are ignored and reads return 0.
- R12: dbg_open_o[0] is for the secure domain and dbg_open_o[1] for the non-secure one. Each bit is 1 when the domain's debug-disable bit is 0 or its password-OK bit is 1.
- R13: The two domains keep separate passwords, counters and flags. An operation in one domain leaves the other domain's registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Warm reset, synchronous, active high |
| por | input | 1 | Cold reset, synchronous, active high; also clears the non-volatile state |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_dbg | input | 1 | Access comes from the external debugger |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after the read |
| irq_o | output | 1 | Shared compare-error interrupt |
| dbg_open_o | output | 2 | Debug allowed per domain (bit 0 secure, bit 1 non-secure) |

## Verification
The shared interrupt can be hit by two events at the same clock edge. One domain's compare can finish with a mismatch just as a write-one-clear removes the other domain's error flag. The bench provokes this by starting a failing secure compare and timing a non-secure status clear to land exactly on the edge where that compare ends. It then requires irq_o to stay high on every cycle around that edge. It also requires the two status registers to show the secure error set and the non-secure error cleared. Clearing the remaining flag must then drop the interrupt exactly one cycle later.

// File: rtl/dpp_pkg.sv
`timescale 1ns/1ps
package dpp_pkg;
  localparam int WORD_W = 32;
  localparam int UCNT_W = 3;
  localparam logic [7:0] WR_KEY = 8'h5A;
  localparam logic [7:0] RD_KEY = 8'hA5;
  // domain-relative byte offsets; the password block must be aligned to its size
  localparam int OFF_CTL = 'h00;
  localparam int OFF_STS = 'h04;
  localparam int OFF_PW0 = 'h10;

  typedef enum logic [1:0] {OP_IDLE, OP_CMP, OP_UPD} op_e;

  typedef struct packed {
    logic ie;    // interrupt enable (secure only)
    logic wdis;  // debugger writes to this domain blocked
    logic adis;  // all debugger access blocked (secure only)
  } cfg_t;
endpackage

// File: rtl/dpp_busy_timer.sv
`timescale 1ns/1ps
module dpp_busy_timer #(
  parameter int CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = (CYC > 1) ? $clog2(CYC) : 1;

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(CYC - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - CNT_W'(1);
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);

  // R5: a window never exceeds OP_CYC cycles
  a_r5_cnt_range: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (cnt_q <= CNT_W'(CYC - 1)));
  // R5: an accepted start opens a full-length window
  a_r5_start_load: assert property (@(posedge clk) disable iff (rst)
    (start && !busy_q) |=> (busy_q && cnt_q == CNT_W'(CYC - 1)));
endmodule

// File: rtl/dpp_domain.sv
`timescale 1ns/1ps
module dpp_domain import dpp_pkg::*; #(
  parameter bit IS_SEC   = 1'b1,
  parameter int PW_WORDS = 4,
  parameter int MAX_FAIL = 3,
  parameter int OP_CYC   = 4,
  parameter logic [PW_WORDS*WORD_W-1:0] PW_INIT = '0
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        por,
  input  logic                        wr_ctl,
  input  logic                        wr_sts,
  input  logic                        wr_pw,
  input  logic [$clog2(PW_WORDS)-1:0] pw_sel,
  input  logic [WORD_W-1:0]           wdata,
  output logic [WORD_W-1:0]           ctl_rd_o,
  output logic [WORD_W-1:0]           sts_rd_o,
  output logic                        busy_o,
  output logic                        err_o,
  output logic                        open_o,
  output cfg_t                        cfg_o
);
  localparam int PW_W    = PW_WORDS * WORD_W;
  localparam int FC_W    = $clog2(MAX_FAIL + 1);
  localparam int UPD_MAX = (1 << UCNT_W) - 1;

  logic hard;
  assign hard = rst | por;

  // non-volatile state: cleared only by cold reset
  logic [PW_W-1:0]   pw_q;
  logic              lock_q, dis_q, pwok_q;
  logic [FC_W-1:0]   fail_q;
  logic [UCNT_W-1:0] ucnt_q;
  // volatile state
  logic              err_q, uok_q;
  cfg_t              cfg_q;
  op_e               op_q;
  logic [WORD_W-1:0] stage_q [PW_WORDS];
  logic [PW_W-1:0]   stage_flat;

  logic busy, done, key_ok, ctl_ok, fmax, start_cmp, start_upd, match;

  dpp_busy_timer #(.CYC(OP_CYC)) u_tmr (
    .clk(clk), .rst(hard), .start(start_cmp | start_upd),
    .busy_o(busy), .done_o(done)
  );

  assign key_ok    = (wdata[31:24] == WR_KEY);
  assign ctl_ok    = wr_ctl && !busy && key_ok;
  assign fmax      = (fail_q == FC_W'(MAX_FAIL));
  assign start_cmp = ctl_ok && wdata[2] && !fmax;
  assign start_upd = ctl_ok && wdata[3] && !wdata[2] && (ucnt_q != UCNT_W'(UPD_MAX));
  assign match     = (pw_q == stage_flat);

  always_comb begin
    for (int i = 0; i < PW_WORDS; i++) stage_flat[i*WORD_W +: WORD_W] = stage_q[i];
  end

  always_ff @(posedge clk) begin
    if (hard) begin
      for (int i = 0; i < PW_WORDS; i++) stage_q[i] <= '0;
    end else if (wr_pw && !busy) begin
      stage_q[pw_sel] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (por) begin
      pw_q   <= PW_INIT;
      lock_q <= 1'b0;
      dis_q  <= 1'b0;
      pwok_q <= 1'b0;
      fail_q <= '0;
      ucnt_q <= '0;
    end else begin
      if (ctl_ok && wdata[0]) dis_q  <= 1'b1;
      if (ctl_ok && wdata[1]) lock_q <= 1'b1;
      if (done && op_q == OP_CMP) begin
        if (match)      pwok_q <= 1'b1;
        else if (!fmax) fail_q <= fail_q + FC_W'(1);
      end
      if (done && op_q == OP_UPD) begin
        pw_q   <= stage_flat;
        ucnt_q <= ucnt_q + UCNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (hard) begin
      err_q <= 1'b0;
      uok_q <= 1'b0;
      cfg_q <= '0;
      op_q  <= OP_IDLE;
    end else begin
      if (ctl_ok) cfg_q <= '{ie: IS_SEC & wdata[8], wdis: wdata[12], adis: IS_SEC & wdata[13]};
      if (start_cmp)      op_q <= OP_CMP;
      else if (start_upd) op_q <= OP_UPD;
      else if (done)      op_q <= OP_IDLE;
      if (done && op_q == OP_CMP && !match) err_q <= 1'b1;
      else if (wr_sts && !busy && wdata[4]) err_q <= 1'b0;
      if (done && op_q == OP_UPD)           uok_q <= 1'b1;
      else if (wr_sts && !busy && wdata[5]) uok_q <= 1'b0;
    end
  end

  assign ctl_rd_o = {RD_KEY, 10'b0, cfg_q.adis, cfg_q.wdis, 3'b0, cfg_q.ie, 4'b0,
                     busy && op_q == OP_UPD, busy && op_q == OP_CMP, lock_q, dis_q};
  assign sts_rd_o = busy ? 32'h1 :
                    {13'b0, pwok_q, lock_q, dis_q, 5'b0, ucnt_q, 1'b0, fmax, uok_q, err_q, 4'b0};
  assign busy_o   = busy;
  assign err_o    = err_q;
  assign open_o   = !dis_q || pwok_q;
  assign cfg_o    = cfg_q;

  // R3: set-only bits survive everything but cold reset
  a_r3_lock_sticky: assert property (@(posedge clk) disable iff (por) lock_q |=> lock_q);
  a_r3_dis_sticky:  assert property (@(posedge clk) disable iff (por) dis_q |=> dis_q);
  // R4: password OK holds until cold reset
  a_r4_pwok_sticky: assert property (@(posedge clk) disable iff (por) pwok_q |=> pwok_q);
  // R2: a keyless control write leaves the configuration untouched
  a_r2_no_key: assert property (@(posedge clk) disable iff (hard)
    (wr_ctl && !key_ok) |=> $stable(cfg_q));
  // R7: no compare starts once the failure limit is reached
  a_r7_no_cmp_at_max: assert property (@(posedge clk) disable iff (hard)
    (fmax && !busy) |=> !(busy && op_q == OP_CMP));
  // R8: update count saturates
  a_r8_cnt_hold: assert property (@(posedge clk) disable iff (por)
    (ucnt_q == UCNT_W'(UPD_MAX)) |=> (ucnt_q == UCNT_W'(UPD_MAX)));
endmodule

// File: rtl/dbg_pwd_guard.sv
`timescale 1ns/1ps
module dbg_pwd_guard import dpp_pkg::*; #(
  parameter int ADDR_W   = 7,
  parameter int PW_WORDS = 4,
  parameter int MAX_FAIL = 3,
  parameter int OP_CYC   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_dbg,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_o,
  output logic [1:0]        dbg_open_o
);
  localparam int OFF_W = ADDR_W - 1;
  localparam int IDX_W = $clog2(PW_WORDS);
  localparam int HI_W  = OFF_W - IDX_W - 2;

  logic              dom;
  logic [OFF_W-1:0]  off;
  logic              is_ctl, is_sts, is_pw;
  logic              blk_all, wr_ok, irq_src, irq_q;
  logic [1:0]        wr_ctl, wr_sts, wr_pw, err, busy, open;
  logic [WORD_W-1:0] ctl_rd [2];
  logic [WORD_W-1:0] sts_rd [2];
  cfg_t              cfg [2];
  logic [WORD_W-1:0] rd_val;

  assign dom     = bus_addr[ADDR_W-1];
  assign off     = bus_addr[OFF_W-1:0];
  assign is_ctl  = (off == OFF_W'(OFF_CTL));
  assign is_sts  = (off == OFF_W'(OFF_STS));
  assign is_pw   = (off[OFF_W-1:IDX_W+2] == HI_W'(OFF_PW0 >> (IDX_W + 2))) && (off[1:0] == 2'b00);
  assign blk_all = bus_dbg && cfg[0].adis;
  assign wr_ok   = bus_sel && bus_wr && !blk_all && !(bus_dbg && cfg[dom].wdis);

  for (genvar g = 0; g < 2; g++) begin : g_dom
    logic hit;
    assign hit       = (dom == 1'(g));
    assign wr_ctl[g] = wr_ok && hit && is_ctl;
    assign wr_sts[g] = wr_ok && hit && is_sts;
    assign wr_pw[g]  = wr_ok && hit && is_pw;

    dpp_domain #(
      .IS_SEC(g == 0), .PW_WORDS(PW_WORDS), .MAX_FAIL(MAX_FAIL), .OP_CYC(OP_CYC)
    ) u_dom (
      .clk(clk), .rst(rst), .por(por),
      .wr_ctl(wr_ctl[g]), .wr_sts(wr_sts[g]), .wr_pw(wr_pw[g]),
      .pw_sel(off[IDX_W+1:2]), .wdata(bus_wdata),
      .ctl_rd_o(ctl_rd[g]), .sts_rd_o(sts_rd[g]),
      .busy_o(busy[g]), .err_o(err[g]), .open_o(open[g]), .cfg_o(cfg[g])
    );
  end

  assign irq_src = cfg[0].ie && (err[0] || err[1]);

  always_comb begin
    rd_val = '0;
    if (!blk_all) begin
      if (is_ctl)      rd_val = ctl_rd[dom];
      else if (is_sts) rd_val = sts_rd[dom] |
                                ((!dom && !busy[0]) ? {30'b0, irq_src, 1'b0} : 32'b0);
      else if (is_pw)  rd_val = '1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || por) begin
      bus_rdata <= '0;
      irq_q     <= 1'b0;
    end else begin
      if (bus_sel && !bus_wr) bus_rdata <= rd_val;
      irq_q <= irq_src;
    end
  end

  assign irq_o      = irq_q;
  assign dbg_open_o = open;

  // R10: no interrupt without the enable
  a_r10_irq_needs_en: assert property (@(posedge clk) disable iff (rst || por)
    !cfg[0].ie |=> !irq_o);
  // R11: a blocked debugger read returns zero
  a_r11_locked_read: assert property (@(posedge clk) disable iff (rst || por)
    (bus_sel && !bus_wr && bus_dbg && cfg[0].adis) |=> (bus_rdata == '0));
endmodule

// File: tb/sim_dbg_pwd_guard.sv
`timescale 1ns/1ps
module sim_dbg_pwd_guard;
  logic        clk = 1'b0;
  logic        rst = 1'b1, por = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_dbg = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  logic [1:0]  dbg_open_o;
  int n_chk = 0, n_bad = 0;
  logic [31:0] rv;

  always #4 clk = ~clk;

  dbg_pwd_guard u0 (.clk(clk), .rst(rst), .por(por), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_dbg(bus_dbg), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .dbg_open_o(dbg_open_o));

  // {kind(1=write), idle, addr, data, expected read, requirement}
  localparam int NV = 26;
  localparam logic [87:0] VT [NV] = '{
    {4'h0, 4'd0, 8'h04, 32'h0,        32'h00000000, 8'd1},  // R1
    {4'h0, 4'd0, 8'h00, 32'h0,        32'hA5000000, 8'd1},  // R1
    {4'h0, 4'd0, 8'h44, 32'h0,        32'h00000000, 8'd1},  // R1
    {4'h0, 4'd0, 8'h10, 32'h0,        32'hFFFFFFFF, 8'd9},  // R9
    {4'h1, 4'd0, 8'h00, 32'h00000003, 32'h0,        8'd2},  // R2 no key
    {4'h0, 4'd0, 8'h00, 32'h0,        32'hA5000000, 8'd2},
    {4'h1, 4'd0, 8'h00, 32'h5A000001, 32'h0,        8'd3},  // R3 set dbgdis
    {4'h0, 4'd0, 8'h00, 32'h0,        32'hA5000001, 8'd3},
    {4'h1, 4'd0, 8'h00, 32'h5A000000, 32'h0,        8'd3},  // R3 no clear
    {4'h0, 4'd0, 8'h00, 32'h0,        32'hA5000001, 8'd3},
    {4'h1, 4'd0, 8'h10, 32'h11111111, 32'h0,        8'd4},  // R4 wrong word
    {4'h1, 4'd0, 8'h00, 32'h5A000004, 32'h0,        8'd4},
    {4'h0, 4'd0, 8'h04, 32'h0,        32'h00000001, 8'd5},  // R5 busy view
    {4'h1, 4'd4, 8'h00, 32'h5A000002, 32'h0,        8'd5},  // R5 ignored
    {4'h0, 4'd0, 8'h04, 32'h0,        32'h00010010, 8'd4},  // R4 error, no lock
    {4'h1, 4'd0, 8'h04, 32'h00000010, 32'h0,        8'd6},  // R6
    {4'h0, 4'd0, 8'h04, 32'h0,        32'h00010000, 8'd6},
    {4'h1, 4'd0, 8'h10, 32'h00000000, 32'h0,        8'd4},
    {4'h1, 4'd5, 8'h00, 32'h5A000004, 32'h0,        8'd4},
    {4'h0, 4'd0, 8'h04, 32'h0,        32'h00050000, 8'd4},  // R4 match
    {4'h1, 4'd0, 8'h10, 32'hCAFEF00D, 32'h0,        8'd8},
    {4'h1, 4'd5, 8'h00, 32'h5A000008, 32'h0,        8'd8},
    {4'h0, 4'd0, 8'h04, 32'h0,        32'h00050120, 8'd8},  // R8
    {4'h1, 4'd0, 8'h04, 32'h00000020, 32'h0,        8'd6},
    {4'h0, 4'd0, 8'h04, 32'h0,        32'h00050100, 8'd6},
    {4'h0, 4'd0, 8'h44, 32'h0,        32'h00000000, 8'd13}  // R13
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [6:0] a, input logic [31:0] d, input logic dbg = 1'b0);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_dbg = dbg; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_dbg = 1'b0;
  endtask

  task automatic brd(input logic [6:0] a, output logic [31:0] d, input logic dbg = 1'b0);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_dbg = dbg; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0; bus_dbg = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rdchk(input string req, input logic [6:0] a, input logic [31:0] exp,
                       input logic dbg = 1'b0);
    logic [31:0] d;
    brd(a, d, dbg);
    chk(req, d, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0; por = 1'b0;
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
    chk("R1 open", {30'b0, dbg_open_o}, 32'h3);

    for (int i = 0; i < NV; i++) begin
      if (VT[i][87:84] == 4'h1) bwr(VT[i][78:72], VT[i][71:40]);
      else begin
        brd(VT[i][78:72], rv);
        chk($sformatf("R%0d vec %0d", VT[i][7:0], i), rv, VT[i][39:8]);
      end
      repeat (int'(VT[i][83:80])) @(negedge clk);
    end

    // R12 / R13: open outputs per domain
    chk("R12 open", {30'b0, dbg_open_o}, 32'h3);
    bwr(7'h40, 32'h5A000001);
    chk("R12 ns closed", {30'b0, dbg_open_o}, 32'h1);
    rdchk("R13 ns", 7'h44, 32'h00010000);
    rdchk("R13 s", 7'h04, 32'h00050100);

    // R7: failure lockout on the non-secure domain
    bwr(7'h50, 32'h00000001);
    for (int k = 0; k < 3; k++) begin
      bwr(7'h40, 32'h5A000004);
      repeat (6) @(negedge clk);
    end
    rdchk("R7 max", 7'h44, 32'h00010050);
    bwr(7'h40, 32'h5A000004);
    rdchk("R7 refused", 7'h44, 32'h00010050);

    // R10: interrupt, with a secure error set on the same edge as a non-secure clear
    chk("R10 off", {31'b0, irq_o}, 32'h0);
    bwr(7'h00, 32'h5A000100);
    rdchk("R10 sts", 7'h04, 32'h00050102);
    chk("R10 on", {31'b0, irq_o}, 32'h1);
    bwr(7'h10, 32'h00000005);
    bwr(7'h00, 32'h5A000104);
    repeat (2) @(negedge clk);
    bwr(7'h44, 32'h00000010);
    for (int k = 0; k < 4; k++) begin
      chk("R10 held", {31'b0, irq_o}, 32'h1);
      @(negedge clk);
    end
    rdchk("R10 s err", 7'h04, 32'h00050112);
    rdchk("R10 ns clr", 7'h44, 32'h00010040);
    bwr(7'h04, 32'h00000010);
    chk("R10 lag", {31'b0, irq_o}, 32'h1);
    @(negedge clk);
    chk("R10 drop", {31'b0, irq_o}, 32'h0);

    // R11: debugger blocking
    bwr(7'h40, 32'h5A001000);
    bwr(7'h40, 32'h5A000002, 1'b1);
    rdchk("R11 wdis", 7'h40, 32'hA5001001);
    bwr(7'h00, 32'h5A002100);
    rdchk("R11 dbg rd", 7'h04, 32'h0, 1'b1);
    rdchk("R11 cpu rd", 7'h04, 32'h00050100);
    bwr(7'h00, 32'h5A000002, 1'b1);
    rdchk("R11 dbg wr", 7'h00, 32'hA5002101);

    // R3: warm reset keeps the non-volatile state
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rdchk("R3 warm s", 7'h04, 32'h00050100);
    rdchk("R3 warm ctl", 7'h00, 32'hA5000001);
    rdchk("R3 warm ns", 7'h44, 32'h00010040);
    chk("R3 warm open", {30'b0, dbg_open_o}, 32'h1);

    // R1: cold reset clears everything
    @(negedge clk); por = 1'b1;
    @(negedge clk); por = 1'b0;
    rdchk("R1 cold s", 7'h04, 32'h0);
    rdchk("R1 cold ns", 7'h44, 32'h0);
    chk("R1 cold open", {30'b0, dbg_open_o}, 32'h3);

    // R8: both bits set runs only the compare, then the update limit
    bwr(7'h00, 32'h5A00000C);
    repeat (6) @(negedge clk);
    rdchk("R8 cmp only", 7'h04, 32'h00040000);
    for (int k = 0; k < 7; k++) begin
      for (int w = 0; w < 4; w++) bwr(7'(7'h10 + 4 * w), 32'h100 * (w + 1) + k);
      bwr(7'h00, 32'h5A000008);
      repeat (6) @(negedge clk);
    end
    rdchk("R8 cnt7", 7'h04, 32'h00040720);
    bwr(7'h00, 32'h5A000008);
    rdchk("R8 refused", 7'h04, 32'h00040720);

    // R9: the top word takes part in the compare
    bwr(7'h00, 32'h5A000004);
    repeat (6) @(negedge clk);
    rdchk("R9 match", 7'h04, 32'h00040720);
    bwr(7'h1C, 32'h12345678);
    bwr(7'h00, 32'h5A000004);
    repeat (6) @(negedge clk);
    rdchk("R9 word3", 7'h04, 32'h00040730);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule